// File: doc/BRIEF.md
# Flash Control Register Guard

This block holds the two byte-wide flash control registers of a small microcontroller. The registers sit on a simple CPU bus with an address, a write strobe, a read strobe and a data byte. It also sits between the CPU and three other parts: the erase engine, the rewrite-mode logic and the flash array's per-block write gates.

Two bits are key bits: the erase-suspend enable in control register 1 and the all-user-block erase/write enable in control register 2. Software sets a key bit only by writing 0 to it and then writing 1 to it on the very next bus write. A single write of 0 clears a key bit.

The block drives a suspend line to the erase engine and keeps a read-only suspend flag. The flag follows the engine's start, done and acknowledge events. The block also produces one erase/write permit per memory block:
- two 8KB user blocks,
- one 16KB user block,
- two 2KB data blocks.

Each permit is gated by rewrite mode, by the all-user enable and by the 8KB enable input, as the permit requirement below lists.

Top module: `flash_ctl_guard`

## Requirements
- R1: After reset, control register 1 (address 0x0FE1) reads 0x40 and control register 2 (address 0x0FE2) reads 0x01. The suspend output is 0 after reset.
- R2: A key bit (bit 0 of either register) becomes 1 only when a bus write of 1 to it directly follows a bus write to the same register that put 0 in that bit. No other bus write may come between the two.
- R3: Any write to a register with bit 0 equal to 0 clears that register's key bit on the next clock.
- R4: A write of 1 to a key bit that is not directly preceded by a 0-write to the same register leaves the bit unchanged. This covers an unrelated write in between and a repeated 1-write.
- R5: Bit 1 of register 1 stores the suspend request as written. The suspend output is 1 exactly while both the suspend enable (bit 0) and the request are 1.
- R6: Bit 6 of register 1 is the suspend flag and cannot be written. A one-cycle erase-start pulse clears it. An erase-done pulse or a suspend acknowledge sets it. When start and another event arrive in the same cycle, start wins.
- R7: Unused bits always read 0: bits 7 and 5..2 of register 1, and bits 7..1 of register 2. Writing 1 to them has no effect.
- R8: While rewrite mode is 0, all five permit outputs are 0.
- R9: The permit bit order is [0] 8KB block 0, [1] 8KB block 1, [2] 16KB block 2, [3] data block A, [4] data block B. Blocks 0 and 1 are permitted only when rewrite mode, the all-user enable and the 8KB enable input are all 1. Block 2 needs rewrite mode and the all-user enable. The data blocks need rewrite mode only.
- R10: The read data is 0 while the read strobe is low or while the address matches neither register. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bus address |
| wr_i | input | 1 | Write strobe, one write per cycle it is high |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rewrite_mode_i | input | 1 | CPU rewrite-mode select |
| blk8k_en_i | input | 1 | Extra enable for the two 8KB user blocks |
| erase_start_i | input | 1 | Pulse: erase engine starts or resumes an erase |
| erase_done_i | input | 1 | Pulse: erase engine finished |
| susp_ack_i | input | 1 | Pulse: erase engine has suspended |
| suspend_o | output | 1 | Suspend request to the erase engine |
| permit_o | output | 5 | Per-block erase/write permit |

## Verification
The hardest situation to reach from the ports is an arming sequence that is broken without any change to the key bit. Three cases matter:
- a 0-write followed by a write to the other register and then a 1-write,
- a 1-write after a set has already used up the arming,
- a 0-write and a 1-write to different registers.

The bench builds each of these from its own plain bus writes and reads the key bit back after every step. It also checks the suspend output and the permits, which are the only outward effects of the key bit. The start-wins case of the flag is reached by pulsing start and acknowledge in the same cycle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int unsigned BUS_AW   = 16;
  localparam int unsigned BUS_DW   = 8;
  localparam int unsigned NUM_BLK  = 5;
  localparam int unsigned NUM_USER = 3;
  localparam int unsigned NUM_8K   = 2;

  localparam int unsigned KEY_BIT  = 0;
  localparam int unsigned REQ_BIT  = 1;
  localparam int unsigned FLAG_BIT = 6;

  localparam logic [BUS_DW-1:0] CTL1_RST  = 8'h40;
  localparam logic [BUS_DW-1:0] CTL2_RST  = 8'h01;
  localparam logic [BUS_DW-1:0] CTL1_MASK = 8'h43;
  localparam logic [BUS_DW-1:0] CTL2_MASK = 8'h01;

  typedef enum logic [1:0] {
    BLK_8K   = 2'd0,
    BLK_USER = 2'd1,
    BLK_DATA = 2'd2
  } blk_class_e;

  function automatic blk_class_e blk_class(input int unsigned idx);
    if (idx < NUM_8K)        return BLK_8K;
    else if (idx < NUM_USER) return BLK_USER;
    else                     return BLK_DATA;
  endfunction
endpackage

// File: rtl/key_bit.sv
module key_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_any_i,
  input  logic wr_sel_i,
  input  logic wbit_i,
  output logic q_o
);
  logic q_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= RST_VAL;
      armed_q <= 1'b0;
    end else if (wr_any_i) begin
      if (wr_sel_i && !wbit_i) begin
        q_q     <= 1'b0;
        armed_q <= 1'b1;
      end else begin
        // any other write consumes or breaks the arming
        if (wr_sel_i && armed_q) q_q <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  assign q_o = q_q;

  p_set_needs_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |-> $past(wr_any_i && wr_sel_i && wbit_i && armed_q));

  p_zero_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any_i && wr_sel_i && !wbit_i) |=> !q_q);

  p_no_arm_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any_i && wr_sel_i && wbit_i && !armed_q) |=> $stable(q_q));
endmodule

// File: rtl/suspend_ctl.sv
module suspend_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_wr_i,
  input  logic req_bit_i,
  input  logic en_i,
  input  logic erase_start_i,
  input  logic erase_done_i,
  input  logic susp_ack_i,
  output logic req_o,
  output logic flag_o,
  output logic suspend_o
);
  logic req_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else if (req_wr_i) begin
      req_q <= req_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b1;
    end else if (erase_start_i) begin
      flag_q <= 1'b0;
    end else if (erase_done_i || susp_ack_i) begin
      flag_q <= 1'b1;
    end
  end

  assign req_o     = req_q;
  assign flag_o    = flag_q;
  assign suspend_o = en_i & req_q;

  p_flag_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_i |=> !flag_q);

  p_flag_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!erase_start_i && susp_ack_i) |=> flag_q);

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_wr_i |=> $stable(req_q));
endmodule

// File: rtl/permit_map.sv
module permit_map
  import flash_guard_pkg::*;
#(
  parameter int unsigned NBLK = NUM_BLK
) (
  input  logic            rewrite_mode_i,
  input  logic            all_user_en_i,
  input  logic            blk8k_en_i,
  output logic [NBLK-1:0] permit_o
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam blk_class_e CLS = blk_class(i);
    if (CLS == BLK_8K) begin : g_8k
      assign permit_o[i] = rewrite_mode_i & all_user_en_i & blk8k_en_i;
    end else if (CLS == BLK_USER) begin : g_user
      assign permit_o[i] = rewrite_mode_i & all_user_en_i;
    end else begin : g_data
      assign permit_o[i] = rewrite_mode_i;
    end
  end
endmodule

// File: rtl/flash_ctl_guard.sv
module flash_ctl_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned        AW        = BUS_AW,
  parameter logic [BUS_AW-1:0]  CTL1_ADDR = 16'h0FE1,
  parameter logic [BUS_AW-1:0]  CTL2_ADDR = 16'h0FE2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [BUS_DW-1:0]  wdata_i,
  output logic [BUS_DW-1:0]  rdata_o,
  input  logic               rewrite_mode_i,
  input  logic               blk8k_en_i,
  input  logic               erase_start_i,
  input  logic               erase_done_i,
  input  logic               susp_ack_i,
  output logic               suspend_o,
  output logic [NUM_BLK-1:0] permit_o
);
  logic sel1, sel2, wr1;
  logic susp_en, all_en, req, flag;
  logic [BUS_DW-1:0] view1, view2;

  assign sel1 = (addr_i == AW'(CTL1_ADDR));
  assign sel2 = (addr_i == AW'(CTL2_ADDR));
  assign wr1  = wr_i & sel1;

  key_bit #(.RST_VAL(CTL1_RST[KEY_BIT])) u_susp_key (
    .clk_i, .rst_ni,
    .wr_any_i (wr_i),
    .wr_sel_i (sel1),
    .wbit_i   (wdata_i[KEY_BIT]),
    .q_o      (susp_en)
  );

  key_bit #(.RST_VAL(CTL2_RST[KEY_BIT])) u_user_key (
    .clk_i, .rst_ni,
    .wr_any_i (wr_i),
    .wr_sel_i (sel2),
    .wbit_i   (wdata_i[KEY_BIT]),
    .q_o      (all_en)
  );

  suspend_ctl u_susp (
    .clk_i, .rst_ni,
    .req_wr_i      (wr1),
    .req_bit_i     (wdata_i[REQ_BIT]),
    .en_i          (susp_en),
    .erase_start_i,
    .erase_done_i,
    .susp_ack_i,
    .req_o         (req),
    .flag_o        (flag),
    .suspend_o
  );

  permit_map #(.NBLK(NUM_BLK)) u_perm (
    .rewrite_mode_i,
    .all_user_en_i (all_en),
    .blk8k_en_i,
    .permit_o
  );

  always_comb begin
    view1 = '0;
    view1[KEY_BIT]  = susp_en;
    view1[REQ_BIT]  = req;
    view1[FLAG_BIT] = flag;
    view2 = '0;
    view2[KEY_BIT]  = all_en;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel1)      rdata_o = view1;
      else if (sel2) rdata_o = view2;
    end
  end

  p_rsvd1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1 && |(wdata_i & ~CTL1_MASK)) |=> ((view1 & ~CTL1_MASK) == '0));

  p_rsvd2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel2 && |(wdata_i & ~CTL2_MASK)) |=> ((view2 & ~CTL2_MASK) == '0));

  p_susp_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspend_o) |-> $past(wr1));

  p_perm_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rewrite_mode_i |-> (permit_o == '0));

  p_data_perm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewrite_mode_i |-> (permit_o[4:3] == 2'b11));

  p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/tb_flash_ctl_guard.sv
module tb_flash_ctl_guard;
  localparam time TCLK = 20ns;
  localparam logic [15:0] A1 = 16'h0FE1;
  localparam logic [15:0] A2 = 16'h0FE2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic rwm = 1'b0, b8k = 1'b0;
  logic e_start = 1'b0, e_done = 1'b0, s_ack = 1'b0;
  logic susp;
  logic [4:0] perm;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  flash_ctl_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rewrite_mode_i(rwm), .blk8k_en_i(b8k),
    .erase_start_i(e_start), .erase_done_i(e_done), .susp_ack_i(s_ack),
    .suspend_o(susp), .permit_o(perm)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = '0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0; addr = '0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) e_start = 1'b1;
    if (which == 1) e_done  = 1'b1;
    if (which == 2) s_ack   = 1'b1;
    if (which == 3) begin e_start = 1'b1; s_ack = 1'b1; end
    @(negedge clk);
    e_start = 1'b0; e_done = 1'b0; s_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    rd_chk("R1 ctl1", A1, 8'h40);
    rd_chk("R1 ctl2", A2, 8'h01);
    chk("R1 suspend", {7'b0, susp}, 8'h00);
  endtask

  task automatic test_arm();
    do_reset();
    bus_wr(A1, 8'h01);                 // 1 with no prior 0
    rd_chk("R4 ctl1 no arm", A1, 8'h40);
    bus_wr(A1, 8'h00);
    bus_wr(A1, 8'h01);
    rd_chk("R2 ctl1 armed set", A1, 8'h41);
    bus_wr(A1, 8'h00);
    rd_chk("R3 ctl1 clear", A1, 8'h40);
    bus_wr(A1, 8'h00);
    bus_wr(A2, 8'h01);                 // intervening write to other reg
    bus_wr(A1, 8'h01);
    rd_chk("R4 ctl1 broken seq", A1, 8'h40);
    bus_wr(A2, 8'h00);
    rd_chk("R3 ctl2 clear", A2, 8'h00);
    bus_wr(A2, 8'h00);
    bus_wr(A1, 8'h01);                 // 1 to different reg after 0
    rd_chk("R4 cross reg", A1, 8'h40);
    bus_wr(A2, 8'h01);
    rd_chk("R4 ctl2 after break", A2, 8'h00);
    bus_wr(A2, 8'h00);
    repeat (3) @(negedge clk);         // idle cycles do not break arming
    bus_wr(A2, 8'h01);
    rd_chk("R2 ctl2 set", A2, 8'h01);
  endtask

  task automatic test_suspend();
    do_reset();
    bus_wr(A1, 8'h02);                 // request without enable
    rd_chk("R5 req stored", A1, 8'h42);
    chk("R5 no enable", {7'b0, susp}, 8'h00);
    bus_wr(A1, 8'h02);
    bus_wr(A1, 8'h03);
    chk("R5 suspend on", {7'b0, susp}, 8'h01);
    bus_wr(A1, 8'h01);                 // drop request, keep enable
    chk("R5 restart", {7'b0, susp}, 8'h00);
    rd_chk("R5 en kept", A1, 8'h41);
    bus_wr(A1, 8'h03);
    chk("R5 re-request", {7'b0, susp}, 8'h01);
    bus_wr(A1, 8'h02);                 // clears enable
    chk("R5 enable cleared", {7'b0, susp}, 8'h00);
  endtask

  task automatic test_flag();
    do_reset();
    bus_wr(A1, 8'h00);                 // write 0 to flag bit position
    rd_chk("R6 flag not writable", A1, 8'h40);
    pulse(0);
    rd_chk("R6 start clears", A1, 8'h00);
    bus_wr(A1, 8'h40);
    rd_chk("R6 write 1 ignored", A1, 8'h00);
    pulse(2);
    rd_chk("R6 ack sets", A1, 8'h40);
    pulse(0);
    pulse(1);
    rd_chk("R6 done sets", A1, 8'h40);
    pulse(3);
    rd_chk("R6 start wins", A1, 8'h00);
  endtask

  task automatic test_unused();
    do_reset();
    bus_wr(A1, 8'hBC);
    rd_chk("R7 ctl1 rsvd", A1, 8'h40);
    bus_wr(A2, 8'hFE);
    rd_chk("R7 ctl2 rsvd", A2, 8'h00);
  endtask

  task automatic test_permits();
    do_reset();
    b8k = 1'b1; rwm = 1'b0;
    #1 chk("R8 rewrite off", {3'b0, perm}, 8'h00);
    rwm = 1'b1;
    #1 chk("R9 all on", {3'b0, perm}, 8'h1F);
    b8k = 1'b0;
    #1 chk("R9 8k off", {3'b0, perm}, 8'h1C);
    b8k = 1'b1;
    bus_wr(A2, 8'h00);
    chk("R9 user off", {3'b0, perm}, 8'h18);
    rwm = 1'b0;
    #1 chk("R8 off again", {3'b0, perm}, 8'h00);
    rwm = 1'b1;
    bus_wr(A2, 8'h00);
    bus_wr(A2, 8'h01);
    chk("R9 user rearmed", {3'b0, perm}, 8'h1F);
    rwm = 1'b0; b8k = 1'b0;
  endtask

  task automatic test_read_gate();
    do_reset();
    @(negedge clk);
    addr = A1; rd = 1'b0;
    #1 chk("R10 no strobe", rdata, 8'h00);
    addr = '0;
    rd_chk("R10 unmapped", 16'h0FE3, 8'h00);
    rd_chk("R10 unmapped low", 16'h0FE0, 8'h00);
  endtask

  initial begin
    test_reset();
    test_arm();
    test_suspend();
    test_flag();
    test_unused();
    test_permits();
    test_read_gate();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule